// File: doc/BRIEF.md
# Quarter-Wave Sine Generator

This block turns a 13-bit phase word into a signed 16-bit sine sample. The full circle is 8192 phase steps. Only the first quarter of the waveform is held in a constant table. The two top phase bits fold every other phase onto that quarter. The upper bit of the pair says the sample's sign is flipped. The lower bit says the table is read backwards, from the peak towards zero.

A phase is accepted on any clock where its valid strobe is high. The matching sample appears two clocks later with its own strobe. A new phase can be accepted every cycle, so a phase accumulator can stream straight into the block. The table is computed during elaboration with integer arithmetic, so no memory file or external generator is needed.

Top module: `sine_quarter_lut`

## Requirements
- R1: While `rst_n` is low, and after it is released, `sample_vld` is 0 and `sample` is 0 until the first accepted phase has emerged.
- R2: `sample_vld` goes high exactly two rising edges after the edge that accepts a phase with `phase_vld` high. Phases offered on consecutive cycles give samples on consecutive cycles, in the same order.
- R3: For phases 0 to 2047 (bits 12 and 11 both clear), `sample` equals round(32767·sin(2π·phase/8192)) within ±1. Every such phase other than 0 gives a strictly positive sample.
- R4: When bit 11 is set and bit 12 is clear, the low 11 bits o select table entry 2048−o. So phase 2048 gives exactly +32767.
- R5: Setting bit 12 negates the result exactly: sample(phase+4096) = −sample(phase) for any phase below 4096. Every phase above 4096 gives a strictly negative sample.
- R6: Phases 0 and 4096 give exactly 0, and phase 6144 gives exactly −32767.
- R7: On a cycle where no result emerges, `sample` keeps its last value and `sample_vld` is low. A phase offered with `phase_vld` low has no effect on later outputs.
- R8: Across all 8192 phases, streamed back to back, every sample is within ±1 of round(32767·sin(2π·phase/8192)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_vld | input | 1 | Phase word is valid this cycle |
| phase | input | 13 | Phase, 8192 steps per full cycle |
| sample_vld | output | 1 | Sample output is valid this cycle |
| sample | output | 16 | Signed sine sample, two's complement |

## Verification
A bad fold of the index shows up as a quadrant traced in the wrong direction. A wrong sign flag shows up as a quadrant with the wrong polarity. Either error is visible at `sample` exactly two clocks after the offending phase, and the peak and zero-crossing phases expose it with no tolerance at all. A bad table entry affects only its own phase in each quadrant, so the full sweep is what catches it. A stage register that loses its valid bit or updates without one shows up as a shifted or missing strobe, or as a sample that moves while `sample_vld` is low.

// File: rtl/sine_quarter_lut.sv
module sine_quarter_lut #(
  parameter int PHASE_W  = 13,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       phase_vld,
  input  logic [PHASE_W-1:0]         phase,
  output logic                       sample_vld,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam int IDX_W   = PHASE_W - 2;
  localparam int TAB_LEN = (1 << IDX_W) + 1;
  localparam int AW      = IDX_W + 1;
  localparam longint AMP   = (64'sd1 <<< (SAMPLE_W - 1)) - 1;
  localparam longint PI_Q30 = 64'sd3373259426;

  typedef logic [TAB_LEN-1:0][SAMPLE_W-1:0] rom_t;

  function automatic rom_t build_rom();
    rom_t   r;
    longint x, x2, term, acc, v;
    r = '0;
    for (int k = 0; k < TAB_LEN; k++) begin
      x    = (longint'(k) * PI_Q30) >>> (IDX_W + 1);
      x2   = (x * x) >>> 30;
      term = x;
      acc  = x;
      for (int n = 1; n <= 8; n++) begin
        term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
        acc  = acc + term;
      end
      v = (acc * AMP + (64'sd1 <<< 29)) >>> 30;
      if (v > AMP) v = AMP;
      if (v < 0)   v = 0;
      r[k] = v[SAMPLE_W-1:0];
    end
    return r;
  endfunction

  localparam rom_t ROM = build_rom();

  logic [IDX_W-1:0] offs;
  logic [AW-1:0]    fold_idx;
  logic [AW-1:0]    s1_idx;
  logic             s1_neg;
  logic             s1_vld;
  logic [SAMPLE_W-1:0] mag;

  assign offs     = phase[IDX_W-1:0];
  assign fold_idx = phase[IDX_W] ? ({1'b1, {IDX_W{1'b0}}} - {1'b0, offs}) : {1'b0, offs};
  assign mag      = ROM[s1_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_idx <= '0;
      s1_neg <= 1'b0;
    end else begin
      s1_vld <= phase_vld;
      if (phase_vld) begin
        s1_idx <= fold_idx;
        s1_neg <= phase[PHASE_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_vld <= 1'b0;
      sample     <= '0;
    end else begin
      sample_vld <= s1_vld;
      if (s1_vld) sample <= s1_neg ? -$signed(mag) : $signed(mag);
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    phase_vld |-> ##2 sample_vld); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> ($stable(sample) && !sample_vld)); // R7
  AST_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase == PHASE_W'(1 << IDX_W)) |-> ##2 (sample == SAMPLE_W'(AMP))); // R4
  AST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase[PHASE_W-2:0] == '0) |-> ##2 (sample == '0)); // R6
  AST_SIGN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && !phase[PHASE_W-1] && phase[PHASE_W-2:0] != '0) |-> ##2 (sample > 0)); // R3
  AST_SIGN_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_vld && phase[PHASE_W-1] && phase[PHASE_W-2:0] != '0) |-> ##2 (sample < 0)); // R5

endmodule

// File: tb/sine_quarter_lut_tb.sv
module sine_quarter_lut_tb;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               phase_vld = 1'b0;
  logic [12:0]        phase = '0;
  logic               sample_vld;
  logic signed [15:0] sample;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sine_quarter_lut u_dut (
    .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase(phase),
    .sample_vld(sample_vld), .sample(sample)
  );

  function automatic int ref_val(input int p);
    real r;
    r = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 8192.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check(input string req, input int act, input int exp, input int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic one(input int p, output int s);
    @(negedge clk);
    phase_vld = 1'b1;
    phase     = 13'(p);
    @(negedge clk);
    phase_vld = 1'b0;
    @(negedge clk);
    check("R2 strobe", int'(sample_vld), 1, 0);
    s = int'(sample);
  endtask

  task automatic t_reset;
    #1;
    check("R1 vld in reset", int'(sample_vld), 0, 0);
    check("R1 sample in reset", int'(sample), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 vld after reset", int'(sample_vld), 0, 0);
    check("R1 sample after reset", int'(sample), 0, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    phase_vld = 1'b1; phase = 13'd512;
    @(negedge clk);
    phase_vld = 1'b0;
    check("R2 vld after 1 edge", int'(sample_vld), 0, 0);
    @(negedge clk);
    check("R2 vld after 2 edges", int'(sample_vld), 1, 0);
    check("R2 value", int'(sample), ref_val(512), 1);
    @(negedge clk);
    check("R2 vld drops", int'(sample_vld), 0, 0);
    @(negedge clk);
    phase_vld = 1'b1; phase = 13'd100;
    @(negedge clk);
    phase = 13'd3000;
    @(negedge clk);
    phase = 13'd7000;
    check("R2 b2b vld 1", int'(sample_vld), 1, 0);
    check("R2 b2b val 1", int'(sample), ref_val(100), 1);
    @(negedge clk);
    phase_vld = 1'b0;
    check("R2 b2b vld 2", int'(sample_vld), 1, 0);
    check("R2 b2b val 2", int'(sample), ref_val(3000), 1);
    @(negedge clk);
    check("R2 b2b vld 3", int'(sample_vld), 1, 0);
    check("R2 b2b val 3", int'(sample), ref_val(7000), 1);
    @(negedge clk);
    check("R2 b2b end", int'(sample_vld), 0, 0);
  endtask

  task automatic t_exact;
    int s;
    one(0, s);    check("R6 phase 0", s, 0, 0);
    one(4096, s); check("R6 phase 4096", s, 0, 0);
    one(6144, s); check("R6 phase 6144", s, -32767, 0);
    one(2048, s); check("R4 peak 2048", s, 32767, 0);
    one(2049, s); check("R4 mirror 2049", s, ref_val(2047), 1);
    one(4095, s); check("R4 mirror 4095", s, ref_val(1), 1);
    one(1, s);    check("R3 small positive", s, ref_val(1), 1);
  endtask

  task automatic t_symmetry;
    int a, b;
    int ps[6] = '{1, 100, 1024, 2048, 2500, 4095};
    foreach (ps[i]) begin
      one(ps[i], a);
      one(ps[i] + 4096, b);
      check("R5 negation", b, -a, 0);
    end
  endtask

  task automatic t_hold;
    int s;
    one(1024, s);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      phase_vld = 1'b0;
      phase     = 13'(i * 1500 + 7);
      check("R7 vld low", int'(sample_vld), 0, 0);
      check("R7 sample held", int'(sample), s, 0);
    end
    @(negedge clk);
    check("R7 still held", int'(sample), s, 0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 8194; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (!sample_vld) check("R8 stream vld", 0, 1, 0);
        check("R8 sweep", int'(sample), ref_val(i - 2), 1);
      end
      if (i < 8192) begin
        phase_vld = 1'b1;
        phase     = 13'(i);
      end else begin
        phase_vld = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    t_reset;
    t_latency;
    t_exact;
    t_symmetry;
    t_hold;
    t_sweep;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule